// File: doc/BRIEF.md
# Pass-Through Delayed-Read Target Controller

This block terminates memory reads that a bus master sends to a pass-through window. It watches simplified target-side bus signals (frame, master ready, read command, address and decode hits). It answers with target ready, stop and device select. Behind it, a request/acknowledge port fetches one word at a time from a local back end into a one-word read buffer. Every data phase has its own wait budget. A first phase that runs out of time is retried. A later phase of a burst that runs out of time is disconnected.

Data that arrives after a retry stays in the buffer, and its address is remembered. While that word is held, the window is locked. The same address picks the word up and unlocks the window. Any other address in the window is turned away with an immediate retry. Operation-register reads are still answered while the window is locked. With prefetch on, a burst requests the next word as soon as the current one moves. With prefetch off, only the requested word is fetched and no burst runs. A flush enable decides whether a word that is still in flight when a burst is disconnected is kept or thrown away.

Top module: `ptr_read_target`

## Requirements
- R1: After reset, trdy, stop, devsel and be_req are all low, and the first window read issues a fresh back-end request.
- R2: On the first data phase, trdy rises in the cycle after the back end acknowledges. If no word is present by the 16th cycle after the claim, stop is asserted without trdy (a retry).
- R3: On the second or later data phase of a burst, stop is asserted without trdy in the 8th cycle of waiting (a disconnect).
- R4: A word acknowledged after a retry is kept. A later read of the same address gets it with trdy in the first cycle and no new request, and that read unlocks the window.
- R5: While a word is held or a fetch is outstanding, a window read to a different address gets devsel and stop without trdy in its first cycle.
- R6: While be_busy_wr is high, a window read is retried in its first cycle.
- R7: A window read to the address of an outstanding fetch is claimed and completes when that fetch returns. A non-matching address is retried.
- R8: An operation-register read (opreg_hit high) is answered with trdy and opreg_data in its first cycle, even while the window is locked.
- R9: With prefetch_en low, a read that keeps frame high gets trdy and stop together on its first word, and no further request is issued. With prefetch_en high, a burst requests address +4 after each word and continues.
- R10: After a later-phase disconnect, the word still in flight is held for its address when flush_en is low. When flush_en is high it is discarded, and once it returns the window accepts any address.
- R11: A read that hits neither decode, and any write, never raises devsel.
- R12: be_addr carries the address of the word being fetched, steps by 4 within a burst, and holds steady while be_req waits for be_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame | input | 1 | Master holds a transaction open (active high) |
| irdy | input | 1 | Master ready for data (active high) |
| rd_cmd | input | 1 | 1 = read command, 0 = write |
| addr | input | AW | Byte address of the access, sampled at the claim edge |
| region_hit | input | 1 | Address decodes to the pass-through window |
| opreg_hit | input | 1 | Address decodes to the operation registers |
| opreg_data | input | DW | Read data for operation-register accesses |
| prefetch_en | input | 1 | Allow bursts with look-ahead fetch |
| flush_en | input | 1 | Discard in-flight data after a later-phase disconnect |
| be_busy_wr | input | 1 | Back end is busy with a pass-through write |
| trdy | output | 1 | Target ready, data transferred this cycle |
| stop | output | 1 | Target requests termination |
| devsel | output | 1 | Access claimed by this target |
| rdata | output | DW | Read data returned with trdy |
| be_req | output | 1 | Back-end fetch request, held until be_ack |
| be_addr | output | AW | Address of the requested word |
| be_ack | input | 1 | Back end delivers be_data this cycle |
| be_data | input | DW | Word from the back end |

## Verification
The hardest case to reach is a burst that is disconnected on a later phase while its look-ahead fetch is still in flight. How it ends then depends on whether the late word comes back before or after the next master access. The back-end model in the bench takes a separate acknowledge delay for each request. A burst gets a short first delay and a second delay longer than the 8-cycle budget but short enough that the word returns in a known cycle after the disconnect. Reads to the held address, reads to another address, and reads issued before the word returns are then placed around that cycle, with flush on and with flush off.

// File: rtl/ptr_read_target.sv
module ptr_read_target #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int FIRST_LIM = 16,
  parameter int NEXT_LIM = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame,
  input  logic          irdy,
  input  logic          rd_cmd,
  input  logic [AW-1:0] addr,
  input  logic          region_hit,
  input  logic          opreg_hit,
  input  logic [DW-1:0] opreg_data,
  input  logic          prefetch_en,
  input  logic          flush_en,
  input  logic          be_busy_wr,
  output logic          trdy,
  output logic          stop,
  output logic          devsel,
  output logic [DW-1:0] rdata,
  output logic          be_req,
  output logic [AW-1:0] be_addr,
  input  logic          be_ack,
  input  logic [DW-1:0] be_data
);
  localparam int LMAX = (FIRST_LIM > NEXT_LIM) ? FIRST_LIM : NEXT_LIM;
  localparam int CW = $clog2(LMAX + 1);
  localparam logic [CW-1:0] FIRST_END = CW'(FIRST_LIM - 1);
  localparam logic [CW-1:0] NEXT_END = CW'(NEXT_LIM - 1);
  localparam logic [AW-1:0] STEP = AW'(4);

  typedef enum logic [1:0] {S_IDLE, S_DATA, S_RTY, S_OPR} st_t;

  st_t           st;
  logic [AW-1:0] cur_addr, pend_addr;
  logic [DW-1:0] buf_data;
  logic          req_out, drop, buf_valid, first;
  logic [CW-1:0] cnt;

  wire locked  = req_out || buf_valid;
  wire start   = (st == S_IDLE) && frame && rd_cmd;
  wire refuse  = be_busy_wr || drop || (locked && addr != pend_addr);
  wire hit     = buf_valid && (pend_addr == cur_addr);
  wire lim_hit = cnt == (first ? FIRST_END : NEXT_END);
  wire tmo     = (st == S_DATA) && irdy && !hit && lim_hit;

  assign trdy   = ((st == S_DATA) && irdy && hit) || ((st == S_OPR) && irdy);
  assign stop   = (st == S_RTY) || tmo ||
                  (trdy && frame && ((st == S_OPR) || !prefetch_en));
  assign devsel = st != S_IDLE;
  assign rdata  = (st == S_OPR) ? opreg_data : buf_data;
  assign be_req = req_out;
  assign be_addr = pend_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cur_addr  <= '0;
      pend_addr <= '0;
      buf_data  <= '0;
      req_out   <= 1'b0;
      drop      <= 1'b0;
      buf_valid <= 1'b0;
      first     <= 1'b0;
      cnt       <= '0;
    end else begin
      if (be_ack && req_out) begin
        req_out <= 1'b0;
        if (drop) drop <= 1'b0;
        else begin
          buf_valid <= 1'b1;
          buf_data  <= be_data;
        end
      end
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (start) begin
            if (opreg_hit) st <= S_OPR;
            else if (region_hit) begin
              if (refuse) st <= S_RTY;
              else begin
                st       <= S_DATA;
                cur_addr <= addr;
                first    <= 1'b1;
                if (!locked) begin
                  req_out   <= 1'b1;
                  pend_addr <= addr;
                end
              end
            end
          end
        end
        S_DATA: begin
          if (trdy) begin
            buf_valid <= 1'b0;
            cnt       <= '0;
            first     <= 1'b0;
            cur_addr  <= cur_addr + STEP;
            if (frame && prefetch_en) begin
              req_out   <= 1'b1;
              pend_addr <= cur_addr + STEP;
            end else st <= S_IDLE;
          end else if (tmo) begin
            st  <= S_IDLE;
            cnt <= '0;
            if (!first && flush_en) begin
              if (be_ack) buf_valid <= 1'b0;
              else drop <= req_out;
            end
          end else if (!frame && !irdy) begin
            st  <= S_IDLE;
            cnt <= '0;
          end else if (irdy) cnt <= cnt + CW'(1);
        end
        S_RTY: st <= S_IDLE;
        S_OPR: if (irdy || !frame) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module ptr_read_target_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame,
  input logic          prefetch_en,
  input logic          trdy,
  input logic          stop,
  input logic          devsel,
  input logic          be_req,
  input logic          be_ack,
  input logic [AW-1:0] be_addr
);
  // R11
  quiet_unclaimed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !devsel |-> (!trdy && !stop));
  // R2
  stop_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !stop);
  // R9
  no_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!prefetch_en && trdy && frame) |-> stop);
  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (be_req && !be_ack) |=> be_req);
  // R12
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (be_req && !be_ack) |=> $stable(be_addr));
endmodule

bind ptr_read_target ptr_read_target_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame(frame), .prefetch_en(prefetch_en),
  .trdy(trdy), .stop(stop), .devsel(devsel), .be_req(be_req),
  .be_ack(be_ack), .be_addr(be_addr)
);

// File: tb/sim_ptr_read_target.sv
module sim_ptr_read_target;
  localparam int PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam logic [DW-1:0] OPREG_VAL = 32'h0BAD_F00D;
  // delay, expected code (0 done, 1 retry), expected cycle
  localparam int VEC [6][3] = '{'{1, 0, 2}, '{5, 0, 6}, '{14, 0, 15},
                                '{15, 0, 16}, '{16, 1, 16}, '{20, 1, 16}};

  logic clk = 0, rst_n = 0;
  logic frame = 0, irdy = 0, rd_cmd = 1, region_hit = 1, opreg_hit = 0;
  logic prefetch_en = 0, flush_en = 0, be_busy_wr = 0;
  logic [AW-1:0] addr = '0;
  logic trdy, stop, devsel, be_req, be_ack = 0;
  logic [DW-1:0] rdata, be_data = '0;
  logic [AW-1:0] be_addr;

  int checks = 0, errors = 0;
  int dly [8];
  int ai = 0, bcnt = 0;
  logic [AW-1:0] acked_addr = '0;

  int r_code, r_cyc, r_words;
  logic [DW-1:0] r_data;
  bit r_dev;

  ptr_read_target #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .frame(frame), .irdy(irdy), .rd_cmd(rd_cmd),
    .addr(addr), .region_hit(region_hit), .opreg_hit(opreg_hit),
    .opreg_data(OPREG_VAL), .prefetch_en(prefetch_en), .flush_en(flush_en),
    .be_busy_wr(be_busy_wr), .trdy(trdy), .stop(stop), .devsel(devsel),
    .rdata(rdata), .be_req(be_req), .be_addr(be_addr), .be_ack(be_ack),
    .be_data(be_data)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a);
    return a ^ 32'hA5A5_0000;
  endfunction

  always @(negedge clk) begin
    if (be_ack) begin
      be_ack = 0;
      bcnt = 0;
    end else if (be_req) begin
      bcnt++;
      if (dly[ai] != 0 && bcnt == dly[ai]) begin
        be_ack = 1;
        be_data = word_of(be_addr);
        acked_addr = be_addr;
        ai++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_dly(input int d0, input int d1, input int d2);
    for (int i = 0; i < 8; i++) dly[i] = 0;
    dly[0] = d0; dly[1] = d1; dly[2] = d2;
    ai = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // code: 0 done, 1 retry, 2 stop with data, 3 disconnect without data, 7 no response
  task automatic rd(input logic [AW-1:0] a, input int nwords);
    int c;
    bit done;
    c = 0; done = 0; r_words = 0; r_code = 7; r_cyc = 0; r_dev = 0; r_data = '0;
    @(posedge clk); #1;
    frame = 1; irdy = 1; addr = a;
    @(posedge clk); #1;
    if (nwords == 1) frame = 0;
    while (!done && c < 24) begin
      @(negedge clk);
      c++;
      if (devsel) r_dev = 1;
      if (trdy) begin
        r_data = rdata;
        r_words++;
      end
      if (stop) begin
        done = 1;
        r_cyc = c;
        r_code = trdy ? 2 : (r_words == 0 ? 1 : 3);
      end else if (trdy && r_words == nwords) begin
        done = 1;
        r_cyc = c;
        r_code = 0;
      end
      @(posedge clk); #1;
      if (done) begin
        frame = 0; irdy = 0;
      end else if (trdy && r_words == nwords - 1) frame = 0;
    end
    frame = 0; irdy = 0;
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    set_dly(0, 0, 0);
    idle(3);
    // R1 reset state
    chk(!trdy, "R1 trdy", trdy, 0);
    chk(!stop, "R1 stop", stop, 0);
    chk(!devsel, "R1 devsel", devsel, 0);
    chk(!be_req, "R1 be_req", be_req, 0);
    @(posedge clk); #1 rst_n = 1;
    idle(2);
    chk(!be_req, "R9 no request before a read", be_req, 0);

    for (int i = 0; i < 6; i++) begin
      logic [AW-1:0] a;
      a = 32'h0000_1000 + AW'(i * 16);
      set_dly(VEC[i][0], 0, 0);
      rd(a, 1);
      chk(r_code == VEC[i][1], "R2 outcome", r_code, VEC[i][1]);
      chk(r_cyc == VEC[i][2], "R2 cycle", r_cyc, VEC[i][2]);
      chk(acked_addr == a || VEC[i][0] > 16, "R12 fetch address", acked_addr, a);
      if (VEC[i][1] == 0) chk(r_data == word_of(a), "R2 data", r_data, word_of(a));
      else begin
        idle(8);
        chk(acked_addr == a, "R12 late fetch address", acked_addr, a);
        rd(a, 1);
        chk(r_code == 0 && r_cyc == 1, "R4 held word on matching read", r_cyc, 1);
        chk(r_data == word_of(a), "R4 held data", r_data, word_of(a));
      end
      idle(2);
    end

    // R4 R5 R8: hold a retried word, probe around it
    set_dly(16, 1, 0);
    rd(32'h2000, 1);
    chk(r_code == 1, "R2 retry at limit", r_code, 1);
    idle(4);
    rd(32'h2040, 1);
    chk(r_code == 1 && r_cyc == 1, "R5 other address retried", r_code, 1);
    chk(!be_req, "R5 no request for other address", be_req, 0);
    region_hit = 0; opreg_hit = 1;
    rd(32'h0010, 1);
    chk(r_code == 0 && r_cyc == 1, "R8 opreg served", r_cyc, 1);
    chk(r_data == OPREG_VAL, "R8 opreg data", r_data, OPREG_VAL);
    region_hit = 1; opreg_hit = 0;
    rd(32'h2000, 1);
    chk(r_code == 0 && r_cyc == 1 && r_data == word_of(32'h2000), "R4 matching read", r_data, word_of(32'h2000));
    rd(32'h2040, 1);
    chk(r_code == 0 && r_cyc == 2, "R4 window released", r_cyc, 2);
    idle(2);

    // R6 busy write
    be_busy_wr = 1;
    set_dly(1, 0, 0);
    rd(32'h2100, 1);
    chk(r_code == 1 && r_cyc == 1, "R6 busy write retry", r_code, 1);
    be_busy_wr = 0;
    idle(2);

    // R7 outstanding fetch
    set_dly(30, 0, 0);
    rd(32'h3000, 1);
    chk(r_code == 1 && r_cyc == 16, "R7 first attempt retried", r_cyc, 16);
    rd(32'h3100, 1);
    chk(r_code == 1 && r_cyc == 1, "R7 non-matching retried", r_code, 1);
    rd(32'h3000, 1);
    chk(r_code == 0 && r_data == word_of(32'h3000), "R7 matching continues", r_data, word_of(32'h3000));
    idle(2);

    // R9 prefetch burst
    prefetch_en = 1;
    set_dly(2, 2, 2);
    rd(32'h4000, 3);
    chk(r_code == 0 && r_words == 3, "R9 burst words", r_words, 3);
    chk(r_cyc == 9, "R9 burst cycles", r_cyc, 9);
    chk(r_data == word_of(32'h4008), "R12 burst last word", r_data, word_of(32'h4008));
    idle(2);

    // R9 no prefetch
    prefetch_en = 0;
    set_dly(2, 2, 2);
    rd(32'h4100, 3);
    chk(r_code == 2 && r_cyc == 3 && r_words == 1, "R9 stop with first word", r_code, 2);
    idle(2);
    chk(!be_req, "R9 no further request", be_req, 0);

    // R3 R10 disconnect, keep
    prefetch_en = 1; flush_en = 0;
    set_dly(2, 12, 0);
    rd(32'h5000, 3);
    chk(r_code == 3 && r_cyc == 11, "R3 later-phase disconnect", r_cyc, 11);
    idle(8);
    rd(32'h5100, 1);
    chk(r_code == 1 && r_cyc == 1, "R10 held, other retried", r_code, 1);
    rd(32'h5004, 1);
    chk(r_code == 0 && r_cyc == 1 && r_data == word_of(32'h5004), "R10 held word delivered", r_data, word_of(32'h5004));
    idle(2);

    // R10 disconnect, flush
    flush_en = 1;
    set_dly(2, 12, 1);
    rd(32'h6000, 3);
    chk(r_code == 3 && r_cyc == 11, "R3 disconnect with flush", r_cyc, 11);
    rd(32'h6100, 1);
    chk(r_code == 1, "R10 retried while discard pending", r_code, 1);
    idle(8);
    rd(32'h6100, 1);
    chk(r_code == 0 && r_cyc == 2 && r_data == word_of(32'h6100), "R10 discarded, window free", r_cyc, 2);
    flush_en = 0; prefetch_en = 0;
    idle(2);

    // R11 unclaimed
    region_hit = 0;
    rd(32'h7000, 1);
    chk(r_code == 7 && !r_dev, "R11 no decode", r_dev, 0);
    region_hit = 1; rd_cmd = 0;
    rd(32'h7000, 1);
    chk(r_code == 7 && !r_dev, "R11 write ignored", r_dev, 0);
    rd_cmd = 1;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule